// File: doc/BRIEF.md
# Delayed One-Shot Pulse Timer

This block is a down-counting timer that produces one output pulse per trigger, after a programmable delay. A trigger comes either from a software start strobe or from an edge on an external trigger pin. The pin passes through a two-stage synchronizer before edge detection. The pin can be disabled, set to react to its rising edge or its falling edge, or set to react to both edges. Once triggered, the timer counts out a wait interval, then drives the output to its active level for a programmable width. It then returns the output to idle and raises a one-cycle interrupt request.

Two reload values are held in registers: one for the wait interval and one for the pulse width. Both can be rewritten at any time through a simple write strobe. While the timer is stopped, a wait-value write also lands in the live counter. While the timer runs, a write touches only the reload register and takes effect at the next reload point, so the shot in progress is never corrupted. A polarity bit picks whether the pulse is high on a low idle level, or low on a high idle level. Clearing the run flag aborts any shot in progress at once.

Top module: `owt_timer`

## Requirements
- R1: After reset the timer is stopped with all controls at 0. `pulse_out` is 0 and `irq` is 0.
- R2: With `run`=1, a `sw_start` strobe sampled at a clock edge starts a shot with wait value N and width value M. The output turns active after the (N+2)th rising edge, counting the sampling edge as the first, and stays active for exactly M+1 cycles.
- R3: With `pol_low`=0 the idle level is 0 and the pulse is 1. With `pol_low`=1 the idle level is 1 and the pulse is 0.
- R4: With `trig_en`=0, edges on `trig_pin` start no shot.
- R5: With `trig_en`=1 and `both_edges`=0, `edge_rise`=1 selects the rising edge and `edge_rise`=0 selects the falling edge. An edge of the other direction starts no shot.
- R6: With `trig_en`=1 and `both_edges`=1, both a rising and a falling pin edge start a shot, whatever `edge_rise` holds.
- R7: The pin changes between clock edges. The output turns active after the (N+4)th rising edge that follows the change, which covers two synchronizer stages and one edge-detect stage.
- R8: `irq` is high for exactly one cycle: the first cycle in which the output is back at idle after a completed pulse.
- R9: A trigger from either source that arrives during the wait or the pulse phase is ignored. The shot in progress keeps its timing and no second pulse follows.
- R10: While `run`=0, a wait-value write (`wr_sel`=0) loads both the reload register and the live counter, so the next shot uses the new value.
- R11: While `run`=1, a wait-value write loads only the reload register. The next shot still uses the previously loaded wait count, and the shot after it uses the new value.
- R12: A width write (`wr_sel`=1) made during the wait phase takes effect in the pulse phase of that same shot.
- R13: Clearing `run` during a shot returns the output to idle after the next clock edge, with no `irq`. While `run`=0 no trigger starts a shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count run flag (1 = run, 0 = stop) |
| trig_en | input | 1 | Enables pin triggering |
| edge_rise | input | 1 | Edge select in single-edge mode: 1 = rising, 0 = falling |
| both_edges | input | 1 | 1 = both pin edges trigger |
| pol_low | input | 1 | Output polarity: 0 = high pulse, 1 = low pulse |
| sw_start | input | 1 | Software start strobe |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| wr_en | input | 1 | Reload write strobe |
| wr_sel | input | 1 | Write target: 0 = wait value, 1 = width value |
| wr_data | input | CW | Reload write data |
| pulse_out | output | 1 | One-shot output pin |
| irq | output | 1 | End-of-pulse interrupt request, one cycle |

## Verification
A wrong phase or counter state shows up at `pulse_out` as a delay or width that is off by whole cycles. The bench measures both directly, counted from the triggering edge, and flags the error on the first shot after the fault. A mis-timed reload appears only on the shot after a running write, so the bench fires two shots back to back after such a write. A stuck or repeated `irq` is seen within one cycle of the pulse ending. A trigger leaking through during a phase shows as a second pulse within about twenty cycles of the first.

// File: rtl/owt_pkg.sv
package owt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_PULSE = 2'd2
    } phase_e;

    typedef struct packed {
        logic run;
        logic trig_en;
        logic edge_rise;
        logic both_edges;
        logic pol_low;
    } ctrl_t;

    function automatic logic out_level(input logic pol_low, input logic active);
        return pol_low ^ active;
    endfunction

endpackage

// File: rtl/owt_trig_detect.sv
module owt_trig_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic enable,
    input  logic edge_rise,
    input  logic both_edges,
    output logic hit
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rise_w, fall_w;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[LAST-1:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign rise_w = sync_q[LAST] & ~prev_q;
    assign fall_w = ~sync_q[LAST] & prev_q;

    always_comb begin
        if (!enable)         hit = 1'b0;
        else if (both_edges) hit = rise_w | fall_w;
        else if (edge_rise)  hit = rise_w;
        else                 hit = fall_w;
    end

    // R4
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !hit);

endmodule

// File: rtl/owt_reload_regs.sv
module owt_reload_regs #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    output logic [CW-1:0] wait_rld,
    output logic [CW-1:0] width_rld,
    output logic          cnt_ld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_rld  <= '0;
            width_rld <= '0;
        end else if (wr_en) begin
            if (wr_sel) width_rld <= wr_data;
            else        wait_rld  <= wr_data;
        end
    end

    // stopped write of the wait value goes straight into the live counter too
    assign cnt_ld = wr_en & ~wr_sel & ~run;

endmodule

// File: rtl/owt_core.sv
module owt_core
    import owt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          go,
    input  logic [CW-1:0] wait_rld,
    input  logic [CW-1:0] width_rld,
    input  logic          cnt_ld,
    input  logic [CW-1:0] ld_data,
    output logic          active,
    output logic          irq
);
    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!run) begin
                phase_q <= PH_IDLE;
                if (phase_q != PH_IDLE) cnt_q <= wait_rld;
                if (cnt_ld)             cnt_q <= ld_data;
            end else begin
                unique case (phase_q)
                    PH_IDLE: begin
                        if (go) phase_q <= PH_WAIT;
                    end
                    PH_WAIT: begin
                        if (cnt_zero) begin
                            phase_q <= PH_PULSE;
                            cnt_q   <= width_rld;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    PH_PULSE: begin
                        if (cnt_zero) begin
                            phase_q <= PH_IDLE;
                            cnt_q   <= wait_rld;
                            irq     <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    assign active = (phase_q == PH_PULSE);

    // R2
    wait_to_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (run && phase_q == PH_WAIT && cnt_zero) |=>
            (phase_q == PH_PULSE && cnt_q == $past(width_rld)));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8
    irq_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (phase_q == PH_IDLE && $past(phase_q) == PH_PULSE));

    // R13
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase_q == PH_IDLE && !irq));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && phase_q == PH_IDLE && !go) |=> $stable(cnt_q));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (run && phase_q == PH_PULSE && !cnt_zero) |=> phase_q == PH_PULSE);

endmodule

// File: rtl/owt_timer.sv
module owt_timer
    import owt_pkg::*;
#(
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          trig_en,
    input  logic          edge_rise,
    input  logic          both_edges,
    input  logic          pol_low,
    input  logic          sw_start,
    input  logic          trig_pin,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [CW-1:0] wr_data,
    output logic          pulse_out,
    output logic          irq
);
    ctrl_t         ctrl;
    logic          pin_hit;
    logic          go;
    logic          active;
    logic [CW-1:0] wait_rld;
    logic [CW-1:0] width_rld;
    logic          cnt_ld;

    assign ctrl = '{run: run, trig_en: trig_en, edge_rise: edge_rise,
                    both_edges: both_edges, pol_low: pol_low};

    owt_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .pin        (trig_pin),
        .enable     (ctrl.trig_en),
        .edge_rise  (ctrl.edge_rise),
        .both_edges (ctrl.both_edges),
        .hit        (pin_hit)
    );

    owt_reload_regs #(.CW(CW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wait_rld  (wait_rld),
        .width_rld (width_rld),
        .cnt_ld    (cnt_ld)
    );

    assign go = pin_hit | sw_start;

    owt_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl.run),
        .go        (go),
        .wait_rld  (wait_rld),
        .width_rld (width_rld),
        .cnt_ld    (cnt_ld),
        .ld_data   (wr_data),
        .active    (active),
        .irq       (irq)
    );

    assign pulse_out = out_level(ctrl.pol_low, active);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pulse_out == pol_low));

endmodule

// File: tb/tb_owt_timer.sv
module tb_owt_timer;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run = 1'b0, trig_en = 1'b0, edge_rise = 1'b0;
    logic          both_edges = 1'b0, pol_low = 1'b0;
    logic          sw_start = 1'b0, trig_pin = 1'b0;
    logic          wr_en = 1'b0, wr_sel = 1'b0;
    logic [CW-1:0] wr_data = '0;
    logic          pulse_out, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    owt_timer #(.CW(CW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .run(run), .trig_en(trig_en),
        .edge_rise(edge_rise), .both_edges(both_edges), .pol_low(pol_low),
        .sw_start(sw_start), .trig_pin(trig_pin), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .pulse_out(pulse_out), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_reg(input bit sel, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = CW'(val);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // fire a shot, measure edges until active, active width and irq
    task automatic shot(input bit use_pin, input bit pin_val,
                        output int dly, output int wid, output bit irq_ok);
        @(negedge clk);
        if (use_pin) trig_pin = pin_val;
        else         sw_start = 1'b1;
        dly = 0;
        do begin
            @(posedge clk); #1;
            sw_start = 1'b0;
            dly++;
            @(negedge clk);
        end while (pulse_out == pol_low && dly < 600);
        wid = 0;
        while (pulse_out != pol_low && wid < 600) begin
            wid++;
            @(negedge clk);
        end
        irq_ok = irq;
        @(negedge clk);
        irq_ok = irq_ok && !irq;
    endtask

    // count active samples over a window
    task automatic quiet(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pulse_out != pol_low || irq) seen++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pulse_out == 1'b0, "R1 out", pulse_out, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_sw_basic();
        int d, w; bit ok;
        write_reg(1'b0, 3);          // stopped write (R10)
        write_reg(1'b1, 2);
        @(negedge clk); run = 1'b1;
        shot(1'b0, 1'b0, d, w, ok);
        check(d == 5, "R2 R10 delay", d, 5);
        check(w == 3, "R2 width", w, 3);
        check(ok, "R8 irq pulse", ok, 1);
    endtask

    task automatic t_polarity();
        int d, w; bit ok;
        @(negedge clk); pol_low = 1'b1;
        @(negedge clk);
        check(pulse_out == 1'b1, "R3 idle high", pulse_out, 1);
        shot(1'b0, 1'b0, d, w, ok);
        check(d == 5 && w == 3, "R3 low pulse delay", d, 5);
        check(ok, "R3 irq", ok, 1);
        @(negedge clk); pol_low = 1'b0;
    endtask

    task automatic t_pin_disabled();
        int s;
        @(negedge clk); trig_en = 1'b0; trig_pin = 1'b1;
        quiet(15, s);
        @(negedge clk); trig_pin = 1'b0;
        quiet(15, s);
        check(s == 0, "R4 pin ignored", s, 0);
    endtask

    task automatic t_single_edges();
        int d, w, s; bit ok;
        @(negedge clk); trig_en = 1'b1; edge_rise = 1'b1; both_edges = 1'b0;
        shot(1'b1, 1'b1, d, w, ok);
        check(d == 7, "R7 R5 rising delay", d, 7);
        check(w == 3, "R5 rising width", w, 3);
        @(negedge clk); trig_pin = 1'b0;
        quiet(20, s);
        check(s == 0, "R5 falling ignored", s, 0);
        @(negedge clk); edge_rise = 1'b0;
        @(negedge clk); trig_pin = 1'b1;
        quiet(20, s);
        check(s == 0, "R5 rising ignored", s, 0);
        shot(1'b1, 1'b0, d, w, ok);
        check(d == 7 && w == 3, "R5 falling delay", d, 7);
    endtask

    task automatic t_both_edges();
        int d, w; bit ok;
        @(negedge clk); both_edges = 1'b1;
        shot(1'b1, 1'b1, d, w, ok);
        check(d == 7 && w == 3, "R6 rising", d, 7);
        shot(1'b1, 1'b0, d, w, ok);
        check(d == 7 && w == 3, "R6 falling", d, 7);
        @(negedge clk); both_edges = 1'b0; trig_en = 1'b0;
    endtask

    task automatic t_retrigger();
        int d, w, s;
        @(negedge clk); sw_start = 1'b1;
        @(posedge clk); #1; sw_start = 1'b0;
        @(negedge clk); sw_start = 1'b1;   // in wait
        @(posedge clk); #1; sw_start = 1'b0;
        d = 2;
        while (pulse_out == pol_low && d < 600) begin
            @(negedge clk);
            if (pulse_out == pol_low) begin @(posedge clk); #1; end
            d++;
        end
        sw_start = 1'b1;                   // in pulse
        @(posedge clk); #1; sw_start = 1'b0;
        w = 0;
        @(negedge clk);
        while (pulse_out != pol_low && w < 600) begin w++; @(negedge clk); end
        check(w == 2, "R9 width kept", w, 2);
        @(negedge clk);
        quiet(20, s);
        check(s == 0, "R9 no second pulse", s, 0);
    endtask

    task automatic t_running_write();
        int d, w; bit ok;
        write_reg(1'b0, 6);
        shot(1'b0, 1'b0, d, w, ok);
        check(d == 5, "R11 old wait", d, 5);
        shot(1'b0, 1'b0, d, w, ok);
        check(d == 8, "R11 new wait", d, 8);
    endtask

    task automatic t_width_in_wait();
        int d, w; bit ok;
        @(negedge clk); sw_start = 1'b1;
        @(posedge clk); #1; sw_start = 1'b0;
        write_reg(1'b1, 5);
        w = 0;
        d = 0;
        while (pulse_out == pol_low && d < 600) begin @(negedge clk); d++; end
        while (pulse_out != pol_low && w < 600) begin w++; @(negedge clk); end
        ok = irq;
        check(w == 6, "R12 width applied", w, 6);
        check(ok, "R12 irq", ok, 1);
    endtask

    task automatic t_abort();
        int s, d, w; bit ok;
        @(negedge clk); sw_start = 1'b1;
        @(posedge clk); #1; sw_start = 1'b0;
        s = 0;
        while (pulse_out == pol_low && s < 600) begin @(negedge clk); s++; end
        @(negedge clk); run = 1'b0;
        @(negedge clk);
        check(pulse_out == pol_low, "R13 abort idle", pulse_out, pol_low);
        quiet(15, s);
        check(s == 0, "R13 no irq after abort", s, 0);
        shot(1'b0, 1'b0, d, w, ok);
        check(d == 600, "R13 stopped start ignored", d, 600);
        write_reg(1'b0, 2);          // stopped write, immediate (R10)
        @(negedge clk); run = 1'b1;
        shot(1'b0, 1'b0, d, w, ok);
        check(d == 4 && w == 6, "R10 stopped load", d, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_sw_basic();
        t_polarity();
        t_pin_disabled();
        t_single_edges();
        t_both_edges();
        t_retrigger();
        t_running_write();
        t_width_in_wait();
        t_abort();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule